// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a slave-only serial register port on a two-wire bus. It holds twenty-nine 8-bit configuration registers, indexed 0 to 28, and shows them all at once on a flat output bus for the logic they configure. The host fills the registers with a block-write frame. The frame is the write address, then a command byte and a byte-count byte, then data bytes. The command and count bytes are acknowledged and thrown away. Data always lands in register 0 first and then in the next register up, one register per byte. The host may end the frame after any complete byte.

A read frame returns a length byte, then the registers from index 0 upward. Register 6 holds the length. Three groups of registers (14–15, 16–17 and 18–20) change together. Bytes for the lower members of a group wait in a shadow store. The whole group is copied into the live registers only when its top byte arrives. A frame that ends partway through a group leaves that group as it was.

The bus lines are sampled by the block's own clock. The slave drives SDA low through an open-drain enable.

Top module: `cfgslv_top`

## Requirements
- R1: The slave acknowledges the address byte D2h (write) and D3h (read). For any other address it does not acknowledge, and it ignores every byte until the next START. It changes its SDA drive only while SCL is low.
- R2: In a write frame, the slave acknowledges the two bytes after the address and discards them. Their values do not affect which register the data goes to.
- R3: Data bytes of a write frame go to registers 0, 1, 2 and so on, in that order. Each byte is acknowledged. Bytes completed before a STOP stay written.
- R4: Registers 14–15, 16–17 and 18–20 each update as one group, on the byte for register 15, 17 or 20. If the frame ends before that byte, none of the group's live registers change.
- R5: A read frame sends, MSB first, register 6's value, then registers 0 upward. The number of registers sent equals that value. After that, and past register 28, the slave sends FFh. A host NACK ends the transmission.
- R6: Register 6 resets to 06h. A write of 00h to it is ignored and the previous value stays.
- R7: Register 10 always reads 00h. Registers 11 and 12 are read-only. Bits [3:0] of register 11 read 0001b.
- R8: In a write frame, a data byte that would go past register 28 is not acknowledged and changes nothing.
- R9: A START or STOP seen partway through a byte abandons that byte and nothing is written. A STOP returns the slave to idle. A START begins a new address byte.
- R10: After reset, every register reads 00h except: register 6 reads 06h, register 11 reads {ID_NIBBLE, 0001b} and register 12 reads REV_ID.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that samples the bus lines |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND value) |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| cfg_o | output | 232 | Live registers; register k sits at bits [8k+7:8k] |

## Verification
The hardest state to reach from the pins is a frame that ends inside a register group. Only the data-byte position tells a group apart, and every frame starts at register 0. So the bench sends frames of 15, 16 and 20 data bytes, which stop one byte short of, exactly on, or partway through the group boundaries. It compares the full register image with its model on every clock. Aborts partway through a byte are reached by driving only a few data bits and then a STOP, or a repeated START that leads into a read. The read then shows that no stray write happened.

// File: rtl/cfgslv_pkg.sv
// Shared constants, register indices, write-strobe type and helpers
// for the SMBus configuration slave. Assumes a fixed bank of 29 bytes.
package cfgslv_pkg;

    localparam int CS_NREG    = 29;
    localparam int CS_IDX_W   = $clog2(CS_NREG + 1);
    localparam int CS_RCNT_W  = 9;

    localparam int REG_COUNT  = 6;
    localparam int REG_RSVD   = 10;
    localparam int REG_IDLO   = 11;
    localparam int REG_IDHI   = 12;

    localparam int GRP_LO     = 14;
    localparam int GRP_HI     = 20;
    localparam int GRP_NB     = GRP_HI - GRP_LO + 1;

    typedef enum logic [2:0] {
        LS_IDLE,
        LS_RX,
        LS_ACK,
        LS_TX,
        LS_HACK
    } link_state_t;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_CMD,
        PH_CNT,
        PH_DATA
    } rx_phase_t;

    typedef struct packed {
        logic                en;
        logic [CS_IDX_W-1:0] idx;
        logic [7:0]          data;
    } cs_wr_t;

    // True for every register inside one of the atomic groups.
    function automatic logic grp_member(input int i);
        return (i >= GRP_LO) && (i <= GRP_HI);
    endfunction

    // True for the register whose arrival commits its group.
    function automatic logic grp_last(input int i);
        return (i == 15) || (i == 17) || (i == 20);
    endfunction

    // Lowest register of the group that holds register i.
    function automatic int grp_first(input int i);
        if (i >= 18) return 18;
        if (i >= 16) return 16;
        return GRP_LO;
    endfunction

endpackage

// File: rtl/cfgslv_pinsync.sv
// Bus line sampler: synchronises SCL and SDA to clk and detects SCL
// edges and START/STOP conditions. Assumes the bus runs far slower than
// clk (standard mode against a clock of tens of MHz).
module cfgslv_pinsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Synchroniser chain plus one history stage; idle bus level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    // Edge and condition decode on the synchronised lines.
    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        bus_start = scl_s & scl_d & sda_d & ~sda_s;
        bus_stop  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/cfgslv_link.sv
// Byte-level protocol engine: shifts address and data bytes in, drives
// acknowledges and read data out, and issues one write strobe per
// accepted data byte. Assumes the host only moves SDA while SCL is low,
// except for START and STOP.
module cfgslv_link
    import cfgslv_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_s,
    input  logic                    sda_s,
    input  logic                    scl_rise,
    input  logic                    scl_fall,
    input  logic                    bus_start,
    input  logic                    bus_stop,
    input  logic [CS_NREG*8-1:0]    cfg_i,
    output logic                    sda_oe,
    output cs_wr_t                  wr_o
);

    link_state_t          state;
    rx_phase_t            phase;
    logic [3:0]           bitcnt;
    logic [7:0]           shreg;
    logic                 ack_q;
    logic                 is_rd;
    logic                 host_ack;
    logic [CS_IDX_W-1:0]  widx;
    logic [CS_RCNT_W-1:0] rdk;
    logic [CS_RCNT_W-1:0] ridx;
    logic [7:0]           tx_byte;
    logic [7:0]           rd_len;

    // Read data select: length byte first, then registers, then FFh.
    always_comb begin
        rd_len  = cfg_i[8*REG_COUNT +: 8];
        ridx    = rdk - 1'b1;
        tx_byte = 8'hFF;
        if (rdk == '0) begin
            tx_byte = rd_len;
        end else begin
            for (int k = 0; k < CS_NREG; k++) begin
                if ((ridx == CS_RCNT_W'(k)) && (ridx < {1'b0, rd_len}))
                    tx_byte = cfg_i[8*k +: 8];
            end
        end
    end

    // Protocol state machine, bit counter and SDA drive register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= LS_IDLE;
            phase    <= PH_ADDR;
            bitcnt   <= '0;
            shreg    <= '0;
            ack_q    <= 1'b0;
            is_rd    <= 1'b0;
            host_ack <= 1'b0;
            widx     <= '0;
            rdk      <= '0;
            sda_oe   <= 1'b0;
            wr_o     <= '0;
        end else begin
            wr_o.en <= 1'b0;
            if (bus_start) begin
                state  <= LS_RX;
                phase  <= PH_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (bus_stop) begin
                state  <= LS_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    LS_IDLE: ;
                    LS_RX: begin
                        if (scl_rise && bitcnt != 4'd8) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            state <= LS_ACK;
                            ack_q <= 1'b1;
                            unique case (phase)
                                PH_ADDR: begin
                                    if (shreg[7:1] == DEV_ADDR) begin
                                        sda_oe <= 1'b1;
                                        is_rd  <= shreg[0];
                                        phase  <= PH_CMD;
                                        rdk    <= '0;
                                    end else begin
                                        ack_q <= 1'b0;
                                    end
                                end
                                PH_CMD: begin
                                    sda_oe <= 1'b1;
                                    phase  <= PH_CNT;
                                end
                                PH_CNT: begin
                                    sda_oe <= 1'b1;
                                    phase  <= PH_DATA;
                                    widx   <= '0;
                                end
                                default: begin
                                    if (widx < CS_IDX_W'(CS_NREG)) begin
                                        sda_oe       <= 1'b1;
                                        wr_o.en      <= 1'b1;
                                        wr_o.idx     <= widx;
                                        wr_o.data    <= shreg;
                                        widx         <= widx + 1'b1;
                                    end else begin
                                        ack_q <= 1'b0;
                                    end
                                end
                            endcase
                        end
                    end
                    LS_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            if (!ack_q) begin
                                state <= LS_IDLE;
                            end else if (is_rd) begin
                                state  <= LS_TX;
                                shreg  <= tx_byte;
                                sda_oe <= ~tx_byte[7];
                                rdk    <= rdk + 1'b1;
                            end else begin
                                state <= LS_RX;
                            end
                        end
                    end
                    LS_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                state  <= LS_HACK;
                                sda_oe <= 1'b0;
                            end else begin
                                shreg  <= {shreg[6:0], 1'b0};
                                sda_oe <= ~shreg[6];
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    end
                    LS_HACK: begin
                        if (scl_rise) begin
                            host_ack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (host_ack) begin
                                state  <= LS_TX;
                                shreg  <= tx_byte;
                                sda_oe <= ~tx_byte[7];
                                bitcnt <= '0;
                                if (rdk != '1) rdk <= rdk + 1'b1;
                            end else begin
                                state <= LS_IDLE;
                            end
                        end
                    end
                    default: state <= LS_IDLE;
                endcase
            end
        end
    end

    // R1: the slave starts pulling SDA only while SCL is low.
    a_r1_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R8: no write strobe ever addresses a register past the bank.
    a_r8_strobe_in_bank: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o.en |-> (wr_o.idx < CS_IDX_W'(CS_NREG)));

    // R9: a STOP leaves the slave idle with SDA released.
    a_r9_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> (state == LS_IDLE) && !sda_oe);

endmodule

// File: rtl/cfgslv_regbank.sv
// Register bank: live configuration bytes, the shadow store for the
// atomic groups, and the write filters for fixed and guarded registers.
// Assumes write strobes arrive in ascending index order within a frame.
module cfgslv_regbank
    import cfgslv_pkg::*;
#(
    parameter logic [3:0] ID_NIBBLE = 4'h2,
    parameter logic [7:0] REV_ID    = 8'h03
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  cs_wr_t               wr_i,
    output logic [CS_NREG*8-1:0] cfg_o
);

    logic [7:0]          live   [CS_NREG];
    logic [7:0]          shadow [GRP_LO:GRP_HI];
    logic [8*GRP_NB-1:0] grp_view;
    int                  widx;

    // Power-on value of register k.
    function automatic logic [7:0] rst_val(input int k);
        if (k == REG_COUNT) return 8'h06;
        if (k == REG_IDLO)  return {ID_NIBBLE, 4'b0001};
        if (k == REG_IDHI)  return REV_ID;
        return 8'h00;
    endfunction

    // Registers that never accept host data.
    function automatic logic fixed_reg(input int k);
        return (k == REG_RSVD) || (k == REG_IDLO) || (k == REG_IDHI);
    endfunction

    assign widx = int'(wr_i.idx);

    // Live and shadow update: group bytes stage, last byte commits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < CS_NREG; k++) live[k] <= rst_val(k);
            for (int j = GRP_LO; j <= GRP_HI; j++) shadow[j] <= 8'h00;
        end else if (wr_i.en) begin
            if (grp_member(widx)) begin
                if (grp_last(widx)) begin
                    for (int j = GRP_LO; j <= GRP_HI; j++) begin
                        if (j >= grp_first(widx) && j < widx) live[j] <= shadow[j];
                    end
                    live[widx] <= wr_i.data;
                end else begin
                    shadow[widx] <= wr_i.data;
                end
            end else if (!fixed_reg(widx) &&
                         !(widx == REG_COUNT && wr_i.data == 8'h00)) begin
                live[widx] <= wr_i.data;
            end
        end
    end

    // Flatten the bank onto the output bus and a group-only view.
    for (genvar g = 0; g < CS_NREG; g++) begin : g_flat
        assign cfg_o[8*g +: 8] = live[g];
    end
    for (genvar h = 0; h < GRP_NB; h++) begin : g_grp
        assign grp_view[8*h +: 8] = live[GRP_LO + h];
    end

    // R4: a byte that does not close its group leaves all group registers alone.
    a_r4_partial_group_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i.en && grp_member(widx) && !grp_last(widx)) |=> $stable(grp_view));

    // R6: the readback length can never become zero.
    a_r6_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        live[REG_COUNT] != 8'h00);

    // R7: reserved register stays clear and the vendor nibble stays fixed.
    a_r7_fixed_regs: assert property (@(posedge clk) disable iff (!rst_n)
        (live[REG_RSVD] == 8'h00) && (live[REG_IDLO][3:0] == 4'b0001));

endmodule

// File: rtl/cfgslv_top.sv
// Top of the SMBus configuration slave: line sampler, protocol engine
// and register bank. Assumes an external open-drain pad driven by sda_oe.
module cfgslv_top
    import cfgslv_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter logic [3:0] ID_NIBBLE   = 4'h2,
    parameter logic [7:0] REV_ID      = 8'h03,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_oe,
    output logic [CS_NREG*8-1:0] cfg_o
);

    logic   scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    cs_wr_t wr;

    cfgslv_pinsync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    cfgslv_link #(.DEV_ADDR(DEV_ADDR)) u_link (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop),
        .cfg_i(cfg_o), .sda_oe(sda_oe), .wr_o(wr)
    );

    cfgslv_regbank #(.ID_NIBBLE(ID_NIBBLE), .REV_ID(REV_ID)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_i(wr), .cfg_o(cfg_o)
    );

endmodule

// File: tb/cfgslv_top_tb.sv
// Bench: behavioural bus host plus a register-image model compared on every clock.
module cfgslv_top_tb;

    localparam int NR = 29;
    localparam int HP = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl_h = 1'b1;
    logic          sda_h = 1'b1;
    logic          sda_oe;
    logic [NR*8-1:0] cfg_o;
    logic          sda_line;

    int    checks = 0;
    int    fails = 0;
    string cur_req = "R10";
    bit    hold_cmp = 1'b1;
    bit    done = 1'b0;
    logic [7:0] m_reg [NR];
    logic [7:0] m_sh  [NR];
    logic [7:0] dat   [40];

    always #4 clk = ~clk;
    assign sda_line = sda_h & ~sda_oe;

    cfgslv_top u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line),
        .sda_oe(sda_oe), .cfg_o(cfg_o)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Model of the register image, written from the requirements.
    function automatic void m_reset();
        for (int k = 0; k < NR; k++) begin m_reg[k] = 8'h00; m_sh[k] = 8'h00; end
        m_reg[6]  = 8'h06;
        m_reg[11] = 8'h21;
        m_reg[12] = 8'h03;
    endfunction

    function automatic void m_write(input int k, input logic [7:0] d);
        int f;
        if (k >= 14 && k <= 20) begin
            if (k == 15 || k == 17 || k == 20) begin
                f = (k == 15) ? 14 : (k == 17) ? 16 : 18;
                for (int j = f; j < k; j++) m_reg[j] = m_sh[j];
                m_reg[k] = d;
            end else begin
                m_sh[k] = d;
            end
        end else if (k == 10 || k == 11 || k == 12) begin
        end else if (k == 6 && d == 8'h00) begin
        end else begin
            m_reg[k] = d;
        end
    endfunction

    function automatic logic [7:0] m_read(input int k);
        if (k == 0) return m_reg[6];
        if ((k - 1) < int'(m_reg[6]) && (k - 1) < NR) return m_reg[k-1];
        return 8'hFF;
    endfunction

    // Whole-image comparison on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !hold_cmp && !done) begin
            for (int k = 0; k < NR; k++) begin
                checks++;
                if (cfg_o[8*k +: 8] !== m_reg[k]) begin
                    fails++;
                    $display("FAIL %s reg%0d act=%0h exp=%0h", cur_req, k,
                             cfg_o[8*k +: 8], m_reg[k]);
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired during %s act=0 exp=1", cur_req);
        summary();
    end

    task automatic bus_start();
        sda_h = 1'b1; tick(HP);
        scl_h = 1'b1; tick(HP);
        sda_h = 1'b0; tick(HP);
        scl_h = 1'b0; tick(2);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; tick(HP);
        scl_h = 1'b1; tick(HP);
        sda_h = 1'b1; tick(HP);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            sda_h = b[7-i]; tick(HP);
            scl_h = 1'b1;   tick(HP);
            scl_h = 1'b0;   tick(2);
        end
    endtask

    // widx >= 0 marks a data byte that the model applies at its 8th falling edge.
    task automatic send_byte(input logic [7:0] b, input int widx, output bit acked);
        for (int i = 0; i < 8; i++) begin
            sda_h = b[7-i]; tick(HP);
            scl_h = 1'b1;   tick(HP);
            if (i == 7) begin
                hold_cmp = 1'b1;
                if (widx >= 0 && widx < NR) m_write(widx, b);
            end
            scl_h = 1'b0;   tick(2);
        end
        sda_h = 1'b1; tick(HP);
        scl_h = 1'b1; tick(HP/2);
        acked = !sda_line;
        hold_cmp = 1'b0;
        tick(HP/2);
        scl_h = 1'b0; tick(2);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            sda_h = 1'b1; tick(HP);
            scl_h = 1'b1; tick(HP/2);
            b[7-i] = sda_line;
            tick(HP/2);
            scl_h = 1'b0; tick(2);
        end
        sda_h = give_ack ? 1'b0 : 1'b1; tick(HP);
        scl_h = 1'b1; tick(HP);
        scl_h = 1'b0; tick(2);
        sda_h = 1'b1;
    endtask

    // Full write frame with n data bytes from dat[].
    task automatic write_xfer(input logic [7:0] cmd, input logic [7:0] cnt, input int n);
        bit a;
        bus_start();
        send_byte(8'hD2, -1, a); chk(a, "R1", "write address ack", a, 1);
        send_byte(cmd, -1, a);   chk(a, "R2", "command byte ack", a, 1);
        send_byte(cnt, -1, a);   chk(a, "R2", "count byte ack", a, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(dat[k], k, a);
            if (k < NR) chk(a, "R3", "data byte ack", a, 1);
            else        chk(!a, "R8", "byte past last register not acked", a, 0);
            if (!a) break;
        end
        bus_stop();
    endtask

    task automatic read_xfer(input int n, input string req);
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD3, -1, a); chk(a, "R1", "read address ack", a, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, b);
            chk(b == m_read(k), req, $sformatf("read byte %0d", k), b, m_read(k));
        end
        bus_stop();
    endtask

    function automatic void fill(input int seed, input logic [7:0] cnt6);
        for (int k = 0; k < 40; k++) dat[k] = 8'((k * 37 + seed) & 255);
        dat[6] = cnt6;
    endfunction

    initial begin
        bit a;
        m_reset();
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R10: reset image
        for (int k = 0; k < NR; k++)
            chk(cfg_o[8*k +: 8] == m_reg[k], "R10", $sformatf("reset reg%0d", k),
                cfg_o[8*k +: 8], m_reg[k]);
        hold_cmp = 1'b0;

        cur_req = "R3";
        fill(5, 8'h06);
        write_xfer(8'h5A, 8'h03, 8);
        cur_req = "R2";
        fill(9, 8'h06);
        write_xfer(8'h14, 8'hFF, 3);

        cur_req = "R5";
        read_xfer(9, "R5");

        cur_req = "R1";
        bus_start();
        send_byte(8'hA0, -1, a); chk(!a, "R1", "foreign address not acked", a, 0);
        send_byte(8'hD2, -1, a); chk(!a, "R1", "ignored until START", a, 0);
        bus_stop();

        cur_req = "R4";
        fill(70, 8'h04);
        write_xfer(8'h00, 8'h00, 15);
        chk(cfg_o[8*14 +: 8] == 8'h00, "R4", "reg14 held on partial group",
            cfg_o[8*14 +: 8], 0);
        fill(71, 8'h04);
        write_xfer(8'h00, 8'h00, 16);
        fill(72, 8'h04);
        write_xfer(8'h00, 8'h00, 20);
        chk(cfg_o[8*18 +: 8] == 8'h00, "R4", "reg18 held on partial group",
            cfg_o[8*18 +: 8], 0);

        cur_req = "R6";
        fill(33, 8'h00);
        dat[10] = 8'hC3; dat[11] = 8'h7E; dat[12] = 8'h5F;
        write_xfer(8'h00, 8'h00, 29);
        chk(cfg_o[8*6 +: 8] == 8'h04, "R6", "zero count write ignored", cfg_o[8*6 +: 8], 4);
        chk(cfg_o[8*10 +: 8] == 8'h00, "R7", "reserved reg stays clear", cfg_o[8*10 +: 8], 0);
        chk(cfg_o[8*11 +: 8] == 8'h21, "R7", "id register read-only", cfg_o[8*11 +: 8], 8'h21);
        chk(cfg_o[8*12 +: 8] == 8'h03, "R7", "revision register read-only", cfg_o[8*12 +: 8], 3);

        cur_req = "R8";
        fill(90, 8'h19);
        write_xfer(8'h00, 8'h00, 31);

        cur_req = "R5";
        read_xfer(27, "R5");

        cur_req = "R9";
        fill(120, 8'h19);
        bus_start();
        send_byte(8'hD2, -1, a); send_byte(8'h00, -1, a); send_byte(8'h00, -1, a);
        send_byte(dat[0], 0, a);
        send_bits(8'h99, 4);
        bus_stop();
        chk(cfg_o[8*1 +: 8] == m_reg[1], "R9", "byte cut by STOP not written",
            cfg_o[8*1 +: 8], m_reg[1]);
        bus_start();
        send_byte(8'hD2, -1, a); send_byte(8'h00, -1, a); send_byte(8'h00, -1, a);
        send_bits(8'h3C, 3);
        bus_start();
        send_byte(8'hD3, -1, a); chk(a, "R9", "repeated START restarts address", a, 1);
        for (int k = 0; k < 3; k++) begin
            logic [7:0] b;
            recv_byte(k < 2, b);
            chk(b == m_read(k), "R9", "read after abort", b, m_read(k));
        end
        bus_stop();

        tick(10);
        summary();
    end

endmodule